// File: doc/BRIEF.md
# Bus Glue with Contention-Free Slow Peripheral Reads

This block decodes addresses and terminates bus cycles for a 32-bit asynchronous CPU bus that sizes its ports dynamically. It drives selects for a boot ROM, a RAM and a slow byte-wide peripheral. For every cycle it returns a port-size acknowledge, a bus fault or an autovector request. All of its outputs are registered on the bus clock.

The slow peripheral takes a long time to release its data lines after its select goes away. This would clash with the device addressed in the next cycle. To avoid that, software reads or writes a peripheral register as a long transfer. The block acknowledges that transfer as a 16-bit port. The CPU then runs a word follow-up cycle by itself. The block answers the follow-up without any select, after a programmable number of wait states. The follow-up cycle therefore acts as a quiet gap on the data bus.

The size lines are fully decoded inside the peripheral window, so any other access shape there ends in a bus fault. Interrupt acknowledge cycles for the peripheral's priority level are completed with an autovector request. Accesses that reach nothing, and writes to ROM, end in a bus fault after a fixed timeout.

Top module: `busglue_top`

## Requirements
- R1: A read with address 0x00000000..0x0003FFFF, outside CPU space, drives `sel_rom_n` low and `port_ack_n` = 2'b00 (32-bit port) from the first clock edge that samples `strobe_n` low. No other select is driven.
- R2: A read or write of any size with address 0x20000000..0x2003FFFF, outside CPU space, drives `sel_ram_n` low and `port_ack_n` = 2'b00 from that same first edge.
- R3: A first peripheral cycle has address 0xA0000000..0xA000003F, `xfer_size` = 2'b00 (long) and address bit 1 = 0, in either direction. It drives `sel_slow_n` low and `port_ack_n` = 2'b01 (only the upper acknowledge line, meaning a 16-bit port) from the first edge.
- R4: A follow-up cycle comes directly after a first peripheral cycle. It has `xfer_size` = 2'b10 (word), address bit 1 = 1 and the same direction as that first cycle. It keeps `sel_slow_n` high throughout. It gets `port_ack_n` = 2'b01 only DUMMY_WAIT edges after the first edge, and all outputs stay idle before that.
- R5: Any other access in the peripheral window gets `bus_fault_n` low from the first edge, with no select and no acknowledge. This covers byte (01) or three-byte (11) size, a long access with address bit 1 = 1, a follow-up with no first cycle directly before it, and a follow-up in the other direction.
- R6: An interrupt acknowledge cycle has `space_code` = 3'b111, address bits 19..16 = 4'hF, and address bits 3..1 equal to IRQ_LEVEL (2). It drives `autovec_n` low from the first edge, with no select and no acknowledge.
- R7: An interrupt acknowledge cycle for any other level gets `bus_fault_n` low from the first edge.
- R8: Some accesses end in `bus_fault_n` low exactly TIMEOUT edges after the first edge. These are a ROM write, an unmapped address, and a CPU-space cycle that is not an interrupt acknowledge (even one whose address falls in ROM). All outputs stay idle before that edge. If the strobe is withdrawn earlier, no fault appears.
- R9: All outputs return high at the first clock edge that samples `strobe_n` high.
- R10: While `rst_n` is low, all outputs are high. Asserting reset in the middle of a cycle releases them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Address strobe, active low |
| addr | input | 32 | Byte address |
| xfer_size | input | 2 | Requested size: 00 long, 01 byte, 10 word, 11 three-byte |
| rd | input | 1 | 1 = read, 0 = write |
| space_code | input | 3 | Address space code; 111 = CPU space |
| sel_rom_n | output | 1 | ROM select |
| sel_ram_n | output | 1 | RAM select |
| sel_slow_n | output | 1 | Slow peripheral select |
| port_ack_n | output | 2 | Port-size acknowledge: 00 = 32-bit, 01 = 16-bit |
| bus_fault_n | output | 1 | Bus error termination |
| autovec_n | output | 1 | Autovector request |

## Verification
The bench builds the block with DUMMY_WAIT = 2 and the default TIMEOUT of 16. The non-zero wait makes the follow-up acknowledge arrive two edges later than the first-cycle acknowledge, so a missing or miscounted stretch is visible. The full timeout window is walked cycle by cycle, so an early or late fault is caught. A two-edge gap also lets the bench withdraw the strobe during the timeout wait and confirm that the aborted cycle leaves no fault behind.

// File: rtl/busglue_pkg.sv
package busglue_pkg;

  localparam logic [1:0] SZ_LONG   = 2'b00;
  localparam logic [1:0] SZ_BYTE   = 2'b01;
  localparam logic [1:0] SZ_WORD   = 2'b10;
  localparam logic [1:0] SZ_TRIPLE = 2'b11;

  localparam logic [2:0] SPACE_CPU = 3'b111;
  localparam logic [3:0] CPU_IACK  = 4'hF;

  localparam int NUM_WIN = 3;
  localparam int WIN_ROM = 0;
  localparam int WIN_RAM = 1;
  localparam int WIN_SLOW = 2;

  typedef enum logic [2:0] {
    AC_TIMEOUT,
    AC_ROM,
    AC_RAM,
    AC_SLOW_FIRST,
    AC_SLOW_GAP,
    AC_AUTOVEC,
    AC_FAULT
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD
  } seq_e;

  // active-high internal view of the registered outputs
  typedef struct packed {
    logic rom;
    logic ram;
    logic slow;
    logic ack_hi;
    logic ack_lo;
    logic fault;
    logic avec;
  } drive_t;

endpackage

// File: rtl/bg_rst_sync.sv
module bg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/bg_region_decode.sv
module bg_region_decode #(
  parameter logic [31:0] ROM_BASE   = 32'h0000_0000,
  parameter logic [31:0] ROM_BYTES  = 32'h0004_0000,
  parameter logic [31:0] RAM_BASE   = 32'h2000_0000,
  parameter logic [31:0] RAM_BYTES  = 32'h0004_0000,
  parameter logic [31:0] SLOW_BASE  = 32'hA000_0000,
  parameter logic [31:0] SLOW_BYTES = 32'h0000_0040
) (
  input  logic [31:0]                    addr,
  output logic [busglue_pkg::NUM_WIN-1:0] hit
);

  localparam int NW = busglue_pkg::NUM_WIN;
  localparam logic [31:0] W_BASE [NW] = '{ROM_BASE, RAM_BASE, SLOW_BASE};
  localparam logic [31:0] W_SPAN [NW] = '{ROM_BYTES, RAM_BYTES, SLOW_BYTES};

  // windows are power-of-two sized and aligned to their size
  for (genvar g = 0; g < NW; g++) begin : g_win
    localparam logic [31:0] KEEP = ~(W_SPAN[g] - 32'd1);
    assign hit[g] = ((addr & KEEP) == W_BASE[g]);
  end

endmodule

// File: rtl/bg_access_classify.sv
module bg_access_classify #(
  parameter logic [2:0] IRQ_LEVEL = 3'd2
) (
  input  logic [busglue_pkg::NUM_WIN-1:0] hit,
  input  logic [1:0]                      xfer_size,
  input  logic                            rd,
  input  logic [2:0]                      space_code,
  input  logic                            a1,
  input  logic [2:0]                      iack_level,
  input  logic [3:0]                      cpu_type,
  input  logic                            gap_armed,
  input  logic                            gap_rd,
  output busglue_pkg::acc_e               cls
);

  import busglue_pkg::*;

  logic cpu_space;
  logic first_shape;
  logic gap_shape;

  assign cpu_space   = (space_code == SPACE_CPU);
  assign first_shape = (xfer_size == SZ_LONG) && !a1;
  assign gap_shape   = (xfer_size == SZ_WORD) && a1 && gap_armed && (gap_rd == rd);

  always_comb begin
    cls = AC_TIMEOUT;
    if (cpu_space) begin
      if (cpu_type == CPU_IACK) begin
        cls = (iack_level == IRQ_LEVEL) ? AC_AUTOVEC : AC_FAULT;
      end
    end else if (hit[WIN_ROM]) begin
      cls = rd ? AC_ROM : AC_TIMEOUT;
    end else if (hit[WIN_RAM]) begin
      cls = AC_RAM;
    end else if (hit[WIN_SLOW]) begin
      if (first_shape)    cls = AC_SLOW_FIRST;
      else if (gap_shape) cls = AC_SLOW_GAP;
      else                cls = AC_FAULT;
    end
  end

endmodule

// File: rtl/bg_term_seq.sv
module bg_term_seq #(
  parameter int DUMMY_WAIT = 3,
  parameter int TIMEOUT    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe_n,
  input  logic                  rd,
  input  busglue_pkg::acc_e     cls,
  output busglue_pkg::drive_t   drive,
  output logic                  gap_armed,
  output logic                  gap_rd
);

  import busglue_pkg::*;

  localparam int MAXW = (TIMEOUT > DUMMY_WAIT) ? TIMEOUT : DUMMY_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] GAP_LOAD = (DUMMY_WAIT > 0) ? CW'(DUMMY_WAIT - 1) : '0;
  localparam logic [CW-1:0] TMO_LOAD = CW'(TIMEOUT - 1);

  seq_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  drive_t        out_q, out_d;
  drive_t        tgt_q, tgt_d;
  logic          arm_q, arm_d;
  logic          ard_q, ard_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    out_d  = out_q;
    tgt_d  = tgt_q;
    arm_d  = arm_q;
    ard_d  = ard_q;
    unique case (st_q)
      ST_IDLE: begin
        out_d = '0;
        if (!strobe_n) begin
          arm_d = (cls == AC_SLOW_FIRST);
          ard_d = rd;
          tgt_d = '0;
          st_d  = ST_HOLD;
          unique case (cls)
            AC_ROM: begin
              out_d.rom    = 1'b1;
              out_d.ack_hi = 1'b1;
              out_d.ack_lo = 1'b1;
            end
            AC_RAM: begin
              out_d.ram    = 1'b1;
              out_d.ack_hi = 1'b1;
              out_d.ack_lo = 1'b1;
            end
            AC_SLOW_FIRST: begin
              out_d.slow   = 1'b1;
              out_d.ack_hi = 1'b1;
            end
            AC_SLOW_GAP: begin
              tgt_d.ack_hi = 1'b1;
              if (DUMMY_WAIT == 0) begin
                out_d = tgt_d;
              end else begin
                cnt_d  = GAP_LOAD;
                cnt_en = 1'b1;
                st_d   = ST_WAIT;
              end
            end
            AC_AUTOVEC: out_d.avec  = 1'b1;
            AC_FAULT:   out_d.fault = 1'b1;
            default: begin
              tgt_d.fault = 1'b1;
              cnt_d       = TMO_LOAD;
              cnt_en      = 1'b1;
              st_d        = ST_WAIT;
            end
          endcase
        end
      end
      ST_WAIT: begin
        if (strobe_n) begin
          out_d = '0;
          st_d  = ST_IDLE;
        end else if (cnt_q == '0) begin
          out_d = tgt_q;
          st_d  = ST_HOLD;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_HOLD: begin
        if (strobe_n) begin
          out_d = '0;
          st_d  = ST_IDLE;
        end
      end
      default: begin
        out_d = '0;
        st_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      out_q <= '0;
      tgt_q <= '0;
      arm_q <= 1'b0;
      ard_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
      tgt_q <= tgt_d;
      arm_q <= arm_d;
      ard_q <= ard_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign drive     = out_q;
  assign gap_armed = arm_q;
  assign gap_rd    = ard_q;

  AST_RELEASE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && $past(strobe_n)) |-> (out_q == '0)); // R9
  AST_WAIT_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (out_q == '0)); // R8
  AST_FAULT_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_WAIT && st_q == ST_HOLD) |-> (out_q.fault || out_q.ack_hi)); // R4

endmodule

// File: rtl/busglue_top.sv
module busglue_top #(
  parameter logic [31:0] ROM_BASE   = 32'h0000_0000,
  parameter logic [31:0] ROM_BYTES  = 32'h0004_0000,
  parameter logic [31:0] RAM_BASE   = 32'h2000_0000,
  parameter logic [31:0] RAM_BYTES  = 32'h0004_0000,
  parameter logic [31:0] SLOW_BASE  = 32'hA000_0000,
  parameter logic [31:0] SLOW_BYTES = 32'h0000_0040,
  parameter logic [2:0]  IRQ_LEVEL  = 3'd2,
  parameter int          DUMMY_WAIT = 3,
  parameter int          TIMEOUT    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strobe_n,
  input  logic [31:0] addr,
  input  logic [1:0]  xfer_size,
  input  logic        rd,
  input  logic [2:0]  space_code,
  output logic        sel_rom_n,
  output logic        sel_ram_n,
  output logic        sel_slow_n,
  output logic [1:0]  port_ack_n,
  output logic        bus_fault_n,
  output logic        autovec_n
);

  import busglue_pkg::*;

  logic               srst_n;
  logic [NUM_WIN-1:0] hit;
  acc_e               cls;
  drive_t             drive;
  logic               gap_armed;
  logic               gap_rd;

  bg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bg_region_decode #(
    .ROM_BASE   (ROM_BASE),
    .ROM_BYTES  (ROM_BYTES),
    .RAM_BASE   (RAM_BASE),
    .RAM_BYTES  (RAM_BYTES),
    .SLOW_BASE  (SLOW_BASE),
    .SLOW_BYTES (SLOW_BYTES)
  ) u_dec (
    .addr (addr),
    .hit  (hit)
  );

  bg_access_classify #(
    .IRQ_LEVEL (IRQ_LEVEL)
  ) u_cls (
    .hit        (hit),
    .xfer_size  (xfer_size),
    .rd         (rd),
    .space_code (space_code),
    .a1         (addr[1]),
    .iack_level (addr[3:1]),
    .cpu_type   (addr[19:16]),
    .gap_armed  (gap_armed),
    .gap_rd     (gap_rd),
    .cls        (cls)
  );

  bg_term_seq #(
    .DUMMY_WAIT (DUMMY_WAIT),
    .TIMEOUT    (TIMEOUT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .strobe_n  (strobe_n),
    .rd        (rd),
    .cls       (cls),
    .drive     (drive),
    .gap_armed (gap_armed),
    .gap_rd    (gap_rd)
  );

  assign sel_rom_n   = ~drive.rom;
  assign sel_ram_n   = ~drive.ram;
  assign sel_slow_n  = ~drive.slow;
  assign port_ack_n  = ~{drive.ack_hi, drive.ack_lo};
  assign bus_fault_n = ~drive.fault;
  assign autovec_n   = ~drive.avec;

  AST_SLOW_SEL_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_slow_n && !strobe_n) |-> (xfer_size == SZ_LONG && !addr[1])); // R4
  AST_SLOW_ACK_16: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_slow_n) |-> (port_ack_n == 2'b01)); // R3
  AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_rom_n && !strobe_n) |-> rd); // R8
  AST_AUTOVEC_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!autovec_n) |-> (sel_rom_n && sel_ram_n && sel_slow_n && port_ack_n == 2'b11)); // R6
  AST_FAULT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_fault_n) |-> (sel_rom_n && sel_ram_n && sel_slow_n && port_ack_n == 2'b11 && autovec_n)); // R5
  AST_NO_CPU_SPACE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && space_code == SPACE_CPU) |=> (sel_rom_n && sel_ram_n && sel_slow_n)); // R6

endmodule

// File: tb/sim_busglue_top.sv
module sim_busglue_top;

  localparam int DW  = 2;
  localparam int TMO = 16;

  localparam logic [6:0] O_IDLE = 7'b1111111;
  localparam logic [6:0] O_ROM  = 7'b0110011;
  localparam logic [6:0] O_RAM  = 7'b1010011;
  localparam logic [6:0] O_SLOW = 7'b1100111;
  localparam logic [6:0] O_GAP  = 7'b1110111;
  localparam logic [6:0] O_FLT  = 7'b1111101;
  localparam logic [6:0] O_AV   = 7'b1111110;

  localparam logic [4:0] L1 = 5'd1;
  localparam logic [4:0] LG = 5'(1 + DW);
  localparam logic [4:0] LT = 5'(1 + TMO);

  localparam logic [2:0] SD  = 3'b101;
  localparam logic [2:0] CPU = 3'b111;

  // {req, addr, size, rd, space, latency, expected}
  localparam int NV = 23;
  localparam logic [53:0] VEC [NV] = '{
    {4'd1,  32'h0000_0100, 2'b00, 1'b1, SD,  L1, O_ROM},  // R1
    {4'd1,  32'h0003_FFFC, 2'b00, 1'b1, SD,  L1, O_ROM},  // R1 top
    {4'd8,  32'h0000_0100, 2'b00, 1'b0, SD,  LT, O_FLT},  // R8 rom write
    {4'd2,  32'h2000_0010, 2'b01, 1'b0, SD,  L1, O_RAM},  // R2
    {4'd2,  32'h2003_FFFC, 2'b00, 1'b1, SD,  L1, O_RAM},  // R2 top
    {4'd8,  32'h2004_0000, 2'b00, 1'b1, SD,  LT, O_FLT},  // R8 past ram
    {4'd3,  32'hA000_0004, 2'b00, 1'b1, SD,  L1, O_SLOW}, // R3
    {4'd4,  32'hA000_0006, 2'b10, 1'b1, SD,  LG, O_GAP},  // R4
    {4'd5,  32'hA000_0006, 2'b10, 1'b1, SD,  L1, O_FLT},  // R5 gap alone
    {4'd5,  32'hA000_0008, 2'b01, 1'b1, SD,  L1, O_FLT},  // R5 byte
    {4'd3,  32'hA000_003C, 2'b00, 1'b1, SD,  L1, O_SLOW}, // R3 last reg
    {4'd4,  32'hA000_003E, 2'b10, 1'b1, SD,  LG, O_GAP},  // R4
    {4'd3,  32'hA000_0010, 2'b00, 1'b0, SD,  L1, O_SLOW}, // R3 write
    {4'd5,  32'hA000_0012, 2'b10, 1'b1, SD,  L1, O_FLT},  // R5 dir flip
    {4'd5,  32'hA000_0002, 2'b00, 1'b1, SD,  L1, O_FLT},  // R5 long a1
    {4'd5,  32'hA000_0000, 2'b11, 1'b1, SD,  L1, O_FLT},  // R5 triple
    {4'd6,  32'h000F_0004, 2'b01, 1'b1, CPU, L1, O_AV},   // R6
    {4'd7,  32'h000F_000A, 2'b01, 1'b1, CPU, L1, O_FLT},  // R7 level 5
    {4'd8,  32'hA000_0040, 2'b00, 1'b1, SD,  LT, O_FLT},  // R8 past window
    {4'd8,  32'h0000_0000, 2'b00, 1'b1, CPU, LT, O_FLT},  // R8 cpu space
    {4'd3,  32'hA000_0020, 2'b00, 1'b1, SD,  L1, O_SLOW}, // R3
    {4'd1,  32'h0000_0200, 2'b00, 1'b1, SD,  L1, O_ROM},  // R1 between
    {4'd5,  32'hA000_0022, 2'b10, 1'b1, SD,  L1, O_FLT}   // R5 broken pair
  };

  logic        clk;
  logic        rst_n;
  logic        strobe_n;
  logic [31:0] addr;
  logic [1:0]  xfer_size;
  logic        rd;
  logic [2:0]  space_code;
  logic        sel_rom_n, sel_ram_n, sel_slow_n, bus_fault_n, autovec_n;
  logic [1:0]  port_ack_n;

  int n_chk;
  int n_bad;
  bit done;

  busglue_top #(
    .DUMMY_WAIT (DW),
    .TIMEOUT    (TMO)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_n    (strobe_n),
    .addr        (addr),
    .xfer_size   (xfer_size),
    .rd          (rd),
    .space_code  (space_code),
    .sel_rom_n   (sel_rom_n),
    .sel_ram_n   (sel_ram_n),
    .sel_slow_n  (sel_slow_n),
    .port_ack_n  (port_ack_n),
    .bus_fault_n (bus_fault_n),
    .autovec_n   (autovec_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] obs();
    return {sel_rom_n, sel_ram_n, sel_slow_n, port_ack_n, bus_fault_n, autovec_n};
  endfunction

  task automatic check(input int req, input logic [6:0] act, input logic [6:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [53:0] v);
    int          req;
    logic [4:0]  lat;
    req = int'(v[53:50]);
    lat = v[11:7];
    @(negedge clk);
    addr       = v[49:18];
    xfer_size  = v[17:16];
    rd         = v[15];
    space_code = v[14:12];
    strobe_n   = 1'b0;
    for (int k = 1; k <= int'(lat); k++) begin
      @(negedge clk);
      if (k < int'(lat)) check(req, obs(), O_IDLE, "quiet before termination");
      else               check(req, obs(), v[6:0], "termination");
    end
    strobe_n = 1'b1;
    @(negedge clk);
    check(9, obs(), O_IDLE, "release after strobe");  // R9
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    strobe_n   = 1'b1;
    addr       = '0;
    xfer_size  = 2'b00;
    rd         = 1'b1;
    space_code = SD;
    repeat (3) @(negedge clk);
    check(10, obs(), O_IDLE, "reset state");  // R10
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(10, obs(), O_IDLE, "idle after reset release");  // R10

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8: strobe withdrawn during the timeout wait leaves no fault
    @(negedge clk);
    addr = 32'h4000_0000; xfer_size = 2'b00; rd = 1'b1; space_code = SD;
    strobe_n = 1'b0;
    repeat (5) @(negedge clk);
    check(8, obs(), O_IDLE, "aborted timeout quiet");
    strobe_n = 1'b1;
    for (int k = 0; k < TMO + 2; k++) begin
      @(negedge clk);
      check(8, obs(), O_IDLE, "aborted timeout no late fault");
    end

    // R10: reset asserted inside a held RAM cycle
    @(negedge clk);
    addr = 32'h2000_0040; xfer_size = 2'b10; rd = 1'b0; space_code = SD;
    strobe_n = 1'b0;
    @(negedge clk);
    check(2, obs(), O_RAM, "ram before reset");  // R2
    rst_n = 1'b0;
    #1;
    check(10, obs(), O_IDLE, "mid-cycle reset");
    strobe_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(10, obs(), O_IDLE, "idle after second reset");

    // R4: a follow-up right after a reset has no first cycle to pair with
    run_vec({4'd5, 32'hA000_0006, 2'b10, 1'b1, SD, L1, O_FLT});  // R5

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule